// File: doc/BRIEF.md
# Endpoint FIFO Unit Allocator

This block manages one pool of endpoint FIFO memory for a USB device controller. The pool is cut into fixed 512-byte units, and a register bitmap holds one occupancy bit per unit. A transmit pool and a receive pool each get their own instance. To reserve space for an endpoint, the caller gives the endpoint's max packet size and a slot count. The block rounds the packet size up to a power of two to get the segment size, and multiplies it by slot+1 to get the reservation size. It then searches the bitmap, lowest index first, for enough contiguous free units. The result is either a FIFO address with the reserved size, or a failure. Typical slot counts are 2 on a SuperSpeed-capable controller and 1 on a USB 2.0-only one.

To release space, the caller gives an address and a size, and the block clears every unit that range covers. Requests are single-cycle pulses accepted while the block is idle. Each request ends with a one-cycle `done` pulse, together with `ok` or `fail`.

Top module: `fifo_bitmap_alloc`

## Requirements
- R1: After reset every unit is free, and `busy`, `done`, `ok` and `fail` are low.
- R2: The segment size is the smallest power of two not below `alloc_maxp`, and the reported `res_size` is (slot+1) times the segment size. A max packet size of 0 fails with `res_size` 0.
- R3: A successful allocation takes ceil(size/512) units. It uses the lowest-indexed run of that many free units, and returns `res_addr` = BASE_ADDR + first_unit*512.
- R4: The units of a successful allocation become occupied. Later allocations do not overlap them.
- R5: A request for more units than LIMIT_UNITS, or one for which no contiguous free run exists, fails and leaves the occupancy unchanged. On failure `res_addr` is 0 and `res_size` is the computed size.
- R6: A free clears exactly the units that overlap [free_addr, free_addr+free_size) within the pool. Freeing units that are already free has no effect. A free completes one cycle after the request, with `ok` high and `res_addr`/`res_size` at 0.
- R7: `done` is a single-cycle pulse, with exactly one of `ok`/`fail` high. An allocation completes no later than LIMIT_UNITS+2 cycles after it is accepted.
- R8: While `busy` is high, `alloc_req` and `free_req` are ignored. If both are pulsed together while idle, the allocation is served and the free is dropped.
- R9: Several small segments that fit in one unit still take one whole unit. For example, a packet size of 100 with slot 2 gives 384 bytes and one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Allocation request pulse |
| alloc_maxp | input | MAXP_W | Endpoint max packet size in bytes |
| alloc_slot | input | SLOT_W | Slot count; the reservation holds slot+1 segments |
| free_req | input | 1 | Release request pulse |
| free_addr | input | ADDR_W | FIFO address of the region to release |
| free_size | input | SIZE_W | Byte size of the region to release |
| busy | output | 1 | A search is in progress |
| done | output | 1 | Request completed (one cycle) |
| ok | output | 1 | Completed request succeeded |
| fail | output | 1 | Completed request failed |
| res_addr | output | ADDR_W | FIFO address of the reservation |
| res_size | output | SIZE_W | Reservation size in bytes |

## Verification
The hardest situation to reach is a request arriving in the middle of a long scan. While the search walks the bitmap, a free or a second allocation pulsed at the ports must be ignored. The bench fills the pool until only the last unit is free, so the scan runs its full length. It then pulses both request lines several times during the scan. A follow-up allocation must fail, which shows the dropped free never cleared anything. Fragmented pools, with a single free hole before a larger one, check that first fit skips runs that are too short.

// File: rtl/fifo_bmap_pkg.sv
package fifo_bmap_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } fsm_e;

    // number of whole units needed to hold a byte count
    function automatic int unsigned units_of(input int unsigned bytes,
                                             input int unsigned lg);
        return (bytes + (32'd1 << lg) - 32'd1) >> lg;
    endfunction

endpackage

// File: rtl/fifo_seg_sizer.sv
module fifo_seg_sizer #(
    parameter int MAXP_W    = 11,
    parameter int SLOT_W    = 2,
    parameter int UNIT_LOG2 = 9,
    parameter int SIZE_W    = MAXP_W + 1 + SLOT_W
) (
    input  logic [MAXP_W-1:0] maxp,
    input  logic [SLOT_W-1:0] slot,
    output logic [SIZE_W-1:0] size,
    output logic [SIZE_W-1:0] units,
    output logic              bad
);
    localparam int SEG_W = MAXP_W + 1;

    logic [SEG_W-1:0] seg;
    logic [31:0]      prod;

    always_comb begin
        seg = '0;
        for (int k = MAXP_W; k >= 0; k--) begin
            if ((32'd1 << k) >= 32'(maxp)) begin
                seg = SEG_W'(32'd1 << k);
            end
        end
    end

    assign bad   = (maxp == '0);
    assign prod  = bad ? 32'd0 : 32'(seg) * (32'(slot) + 32'd1);
    assign size  = SIZE_W'(prod);
    assign units = SIZE_W'(fifo_bmap_pkg::units_of(prod, UNIT_LOG2));

endmodule

// File: rtl/fifo_range_mask.sv
module fifo_range_mask #(
    parameter int BITS = 128
) (
    input  logic [31:0]     first,
    input  logic [31:0]     count,
    output logic [BITS-1:0] mask
);
    logic [31:0] stop;
    assign stop = first + count;

    for (genvar k = 0; k < BITS; k++) begin : g_bit
        assign mask[k] = (32'(k) >= first) && (32'(k) < stop);
    end

endmodule

// File: rtl/fifo_bitmap_alloc.sv
module fifo_bitmap_alloc #(
    parameter int          UNIT_LOG2   = 9,
    parameter int          MAP_BITS    = 128,
    parameter int          LIMIT_UNITS = 128,
    parameter int          MAXP_W      = 11,
    parameter int          SLOT_W      = 2,
    parameter int          ADDR_W      = 20,
    parameter int unsigned BASE_ADDR   = 0,
    localparam int         SIZE_W      = MAXP_W + 1 + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [MAXP_W-1:0] alloc_maxp,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic              free_req,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [SIZE_W-1:0] free_size,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic              fail,
    output logic [ADDR_W-1:0] res_addr,
    output logic [SIZE_W-1:0] res_size
);
    import fifo_bmap_pkg::*;

    localparam int IDX_W = (MAP_BITS > 1) ? $clog2(MAP_BITS) : 1;
    localparam int LAST  = LIMIT_UNITS - 1;

    typedef struct packed {
        fsm_e                st;
        logic [MAP_BITS-1:0] bitmap;
        logic [IDX_W-1:0]    idx;
        logic [SIZE_W-1:0]   run;
        logic [SIZE_W-1:0]   need;
        logic                done;
        logic                ok;
        logic                fail;
        logic [ADDR_W-1:0]   addr;
        logic [SIZE_W-1:0]   rsize;
    } state_t;

    state_t st_d, st_q;

    // request sizing
    logic [SIZE_W-1:0] sz_size, sz_units;
    logic              sz_bad;

    fifo_seg_sizer #(
        .MAXP_W(MAXP_W), .SLOT_W(SLOT_W),
        .UNIT_LOG2(UNIT_LOG2), .SIZE_W(SIZE_W)
    ) u_sizer (
        .maxp(alloc_maxp), .slot(alloc_slot),
        .size(sz_size), .units(sz_units), .bad(sz_bad)
    );

    // run found during scan: start index and set mask
    logic [31:0]         scan_start;
    logic [MAP_BITS-1:0] set_mask;
    assign scan_start = 32'(st_q.idx) + 32'd1 - 32'(st_q.need);

    fifo_range_mask #(.BITS(MAP_BITS)) u_set (
        .first(scan_start), .count(32'(st_q.need)), .mask(set_mask)
    );

    // release range
    logic [31:0]         fr_off, fr_first, fr_end, fr_cnt;
    logic                fr_below;
    logic [MAP_BITS-1:0] clr_raw, clr_mask, pool_mask;

    assign fr_below = 32'(free_addr) < BASE_ADDR;
    assign fr_off   = 32'(free_addr) - BASE_ADDR;
    assign fr_first = fr_off >> UNIT_LOG2;
    assign fr_end   = (fr_off + 32'(free_size) + (32'd1 << UNIT_LOG2) - 32'd1) >> UNIT_LOG2;
    assign fr_cnt   = fr_below ? 32'd0 : (fr_end - fr_first);

    fifo_range_mask #(.BITS(MAP_BITS)) u_clr (
        .first(fr_first), .count(fr_cnt), .mask(clr_raw)
    );

    for (genvar k = 0; k < MAP_BITS; k++) begin : g_pool
        assign pool_mask[k] = (k < LIMIT_UNITS);
    end
    assign clr_mask = clr_raw & pool_mask;

    logic scan_last;
    logic run_hit;
    assign scan_last = (32'(st_q.idx) == 32'(LAST));
    assign run_hit   = ((st_q.run + SIZE_W'(1)) == st_q.need);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ok   = 1'b0;
        st_d.fail = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (alloc_req) begin
                    st_d.rsize = sz_size;
                    if (sz_bad || (32'(sz_units) > 32'(LIMIT_UNITS))) begin
                        st_d.done = 1'b1;
                        st_d.fail = 1'b1;
                        st_d.addr = '0;
                    end else begin
                        st_d.st   = ST_SCAN;
                        st_d.idx  = '0;
                        st_d.run  = '0;
                        st_d.need = sz_units;
                    end
                end else if (free_req) begin
                    st_d.bitmap = st_q.bitmap & ~clr_mask;
                    st_d.done   = 1'b1;
                    st_d.ok     = 1'b1;
                    st_d.addr   = '0;
                    st_d.rsize  = '0;
                end
            end
            ST_SCAN: begin
                if (!st_q.bitmap[st_q.idx]) begin
                    if (run_hit) begin
                        st_d.bitmap = st_q.bitmap | set_mask;
                        st_d.done   = 1'b1;
                        st_d.ok     = 1'b1;
                        st_d.addr   = ADDR_W'(BASE_ADDR + (scan_start << UNIT_LOG2));
                        st_d.st     = ST_IDLE;
                    end else if (scan_last) begin
                        st_d.done = 1'b1;
                        st_d.fail = 1'b1;
                        st_d.addr = '0;
                        st_d.st   = ST_IDLE;
                    end else begin
                        st_d.run = st_q.run + SIZE_W'(1);
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end else begin
                    st_d.run = '0;
                    if (scan_last) begin
                        st_d.done = 1'b1;
                        st_d.fail = 1'b1;
                        st_d.addr = '0;
                        st_d.st   = ST_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.st == ST_SCAN);
    assign done     = st_q.done;
    assign ok       = st_q.ok;
    assign fail     = st_q.fail;
    assign res_addr = st_q.addr;
    assign res_size = st_q.rsize;

endmodule

// File: rtl/fifo_bitmap_alloc_chk.sv
module fifo_bitmap_alloc_chk #(
    parameter int          UNIT_LOG2   = 9,
    parameter int          LIMIT_UNITS = 128,
    parameter int          ADDR_W      = 20,
    parameter int          SIZE_W      = 14,
    parameter int unsigned BASE_ADDR   = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              free_req,
    input logic              busy,
    input logic              done,
    input logic              ok,
    input logic              fail,
    input logic [ADDR_W-1:0] res_addr,
    input logic [SIZE_W-1:0] res_size
);
    logic [31:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 32'd1;
        else           busy_cnt <= '0;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({ok, fail}) == 1));

    p_quiet_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!ok && !fail));

    p_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 32'(LIMIT_UNITS + 1));

    p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !alloc_req && !free_req) |=> !done);

    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && res_size != '0) |->
        (((32'(res_addr) - BASE_ADDR) & ((32'd1 << UNIT_LOG2) - 32'd1)) == 32'd0));

    p_fail_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (res_addr == '0));

endmodule

bind fifo_bitmap_alloc fifo_bitmap_alloc_chk #(
    .UNIT_LOG2(UNIT_LOG2), .LIMIT_UNITS(LIMIT_UNITS),
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/sim_fifo_bitmap_alloc.sv
`timescale 1ns/1ps
module sim_fifo_bitmap_alloc;
    localparam int          LIM    = 12;
    localparam int          MAXP_W = 11;
    localparam int          SLOT_W = 2;
    localparam int          ADDR_W = 20;
    localparam int          SIZE_W = MAXP_W + 1 + SLOT_W;
    localparam int unsigned BASE   = 32'h1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic [MAXP_W-1:0] alloc_maxp = '0;
    logic [SLOT_W-1:0] alloc_slot = '0;
    logic              free_req = 1'b0;
    logic [ADDR_W-1:0] free_addr = '0;
    logic [SIZE_W-1:0] free_size = '0;
    logic              busy, done, ok, fail;
    logic [ADDR_W-1:0] res_addr;
    logic [SIZE_W-1:0] res_size;

    always #2.5 clk = ~clk;

    fifo_bitmap_alloc #(
        .LIMIT_UNITS(LIM), .MAXP_W(MAXP_W), .SLOT_W(SLOT_W),
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE)
    ) u0 (.*);

    typedef struct {
        bit          ok;
        int unsigned addr;
        int unsigned size;
        string       tag;
    } exp_t;

    exp_t q[$];
    bit   mdl[LIM];
    int   checks = 0;
    int   errors = 0;
    int   completions = 0;
    bit   finished = 0;

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            completions++;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected completion addr=%0h size=%0d expected none",
                         res_addr, res_size);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (ok !== e.ok || fail !== !e.ok || 32'(res_addr) != e.addr ||
                    32'(res_size) != e.size) begin
                    errors++;
                    $display("FAIL %s: ok=%0b fail=%0b addr=%0h size=%0d expected ok=%0b addr=%0h size=%0d",
                             e.tag, ok, fail, res_addr, res_size, e.ok, e.addr, e.size);
                end
            end
        end
    end

    task automatic wait_done(input int prev);
        while (completions == prev) @(negedge clk);
    endtask

    function automatic exp_t model_alloc(input int maxp, input int slot, input string tag);
        exp_t e;
        int seg = 0;
        int units;
        e.tag = tag; e.ok = 0; e.addr = 0; e.size = 0;
        if (maxp == 0) return e;
        for (int k = 11; k >= 0; k--) if ((1 << k) >= maxp) seg = 1 << k;
        e.size = (slot + 1) * seg;
        units = (e.size + 511) / 512;
        if (units > LIM) return e;
        for (int s = 0; s + units <= LIM; s++) begin
            bit fits = 1;
            for (int j = s; j < s + units; j++) if (mdl[j]) fits = 0;
            if (fits) begin
                for (int j = s; j < s + units; j++) mdl[j] = 1;
                e.ok = 1;
                e.addr = BASE + s * 512;
                return e;
            end
        end
        return e;
    endfunction

    task automatic do_alloc(input int maxp, input int slot, input string tag,
                            input bit noise = 0);
        int prev = completions;
        q.push_back(model_alloc(maxp, slot, tag));
        @(negedge clk);
        alloc_req = 1; alloc_maxp = MAXP_W'(maxp); alloc_slot = SLOT_W'(slot);
        @(negedge clk);
        alloc_req = 0;
        if (noise) begin
            checks++;
            if (busy !== 1'b1) begin
                errors++;
                $display("FAIL R8: busy=%0b expected 1 during scan", busy);
            end
            repeat (3) begin
                alloc_req = 1; free_req = 1;
                free_addr = ADDR_W'(BASE); free_size = SIZE_W'(2048);
                @(negedge clk);
            end
            alloc_req = 0; free_req = 0;
        end
        wait_done(prev);
    endtask

    task automatic do_free(input int unsigned addr, input int size, input string tag);
        int prev = completions;
        exp_t e;
        int s, en;
        e.tag = tag; e.ok = 1; e.addr = 0; e.size = 0;
        s  = (addr - BASE) / 512;
        en = (addr - BASE + size + 511) / 512;
        for (int j = s; j < en; j++) if (j < LIM) mdl[j] = 0;
        q.push_back(e);
        @(negedge clk);
        free_req = 1; free_addr = ADDR_W'(addr); free_size = SIZE_W'(size);
        @(negedge clk);
        free_req = 0;
        wait_done(prev);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 0 || done !== 0 || ok !== 0 || fail !== 0) begin
            errors++;
            $display("FAIL R1: busy=%0b done=%0b ok=%0b fail=%0b expected 0000",
                     busy, done, ok, fail);
        end
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (busy !== 0 || done !== 0) begin
            errors++;
            $display("FAIL R1: busy=%0b done=%0b expected 00 after release", busy, done);
        end

        do_alloc(512, 1, "R3");          // 2 units at 0
        do_alloc(100, 2, "R9");          // 384 B, 1 unit
        do_alloc(1024, 3, "R4");         // 8 units after the first two
        do_alloc(1024, 3, "R5");         // no run left
        do_free(BASE, 1024, "R6");
        do_free(BASE, 1024, "R6");       // double free
        do_alloc(600, 0, "R2");          // seg 1024, reuses freed units
        do_alloc(2047, 3, "R5");         // 16 units > limit
        do_alloc(0, 1, "R2");            // zero packet size
        do_alloc(512, 0, "R8", 1);       // last unit, noisy ports
        do_alloc(512, 0, "R8");          // full: dropped free had no effect
        do_free(BASE, LIM * 512, "R6");
        do_alloc(2047, 2, "R3");         // exact fit of whole pool
        do_free(BASE + 4 * 512, 512, "R6");
        do_free(BASE + 6 * 512, 1024, "R6");
        do_alloc(300, 1, "R3");          // 2 units: skips hole at 4
        do_alloc(64, 0, "R4");           // 1 unit: lands in hole at 4
        do_alloc(64, 0, "R5");           // full again

        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7: %0d completions missing expected 0", q.size());
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7: watchdog expired, run hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

endmodule